// File: doc/BRIEF.md
# Oversampling Serial Word Receiver

This block turns an asynchronous serial line back into parallel words. A tick
input runs at sixteen times the bit rate. The receiver passes the line through a
synchronizer, waits for a high-to-low transition, and confirms the start bit
halfway through its period. It then samples each later bit at its centre. The
number of data bits, the parity mode and the stop-bit count are set at run time.
The block samples these settings when a start bit is detected, so they must match
the transmitter on the far end.

A word that passes its checks goes into a single holding register and raises a
valid flag, which stays up until the consumer pulses a read strobe. A frame with
a parity or stop-bit fault is thrown away and a one-cycle error pulse reports it.
A good word that lands while the holding register is still full replaces the old
word and raises a one-cycle overrun pulse. After any frame, the line must be seen
high again before a new start bit is accepted.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_valid`, `par_err`, `frame_err` and `overrun` are 0 and `rx_word` is 0.
- R2: Data bits are received least significant first. A frame that passes its checks puts its data bits in the low bits of `rx_word` with zeros above them, and sets `rx_valid`.
- R3: `cfg_len` values 0 to 4 select 5 to 9 data bits (value plus 5). Values 5 to 7 select 9 data bits.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. On a mismatch, `par_err` pulses for one cycle, the word is dropped and `rx_valid` does not change.
- R5: With `cfg_par_en`=0, no parity bit slot exists and the first stop bit directly follows the last data bit.
- R6: If a stop bit is sampled low, `frame_err` pulses for one cycle, the word is dropped and `rx_valid` does not change.
- R7: With `cfg_two_stop`=1, both stop bits are sampled, and a low second stop bit also gives a framing error.
- R8: A low pulse that has ended by the eighth tick after the falling edge is treated as noise. It produces no word and no flag, and the next real frame is received normally.
- R9: A good word that completes while `rx_valid` is 1, with no read in that cycle, pulses `overrun` and replaces the held word. `rx_valid` stays 1.
- R10: A one-cycle `rd_ack` clears `rx_valid`.
- R11: After a frame, including a frame dropped for an error, no new start bit is accepted until the line has been sampled high.
- R12: The receiver advances only on cycles with `os_tick`=1. Each bit lasts 16 ticks, however the ticks are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 3 | Data length code (value + 5, capped at 9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd_ack | input | 1 | Consumer read strobe, clears the valid flag |
| rx_word | output | 9 | Held received word |
| rx_valid | output | 1 | Holding register full |
| par_err | output | 1 | One-cycle parity error pulse |
| frame_err | output | 1 | One-cycle framing error pulse |
| overrun | output | 1 | One-cycle overrun pulse |

## Verification
The bench builds the block with its default parameters: 5 to 9 data bits, 16 ticks per bit and a two-stage synchronizer. With these values, every length code, all three parity settings and both stop counts can be swept with several data patterns each. All 32 words of a 5-bit frame are also run, along with a frame at a slowed tick rate. The small frame sizes make it cheap to place single faults exactly where they matter: a wrong parity bit, a low first or second stop bit, a start pulse that is too short, and a line held low after a bad frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int MIN_BITS = 5,
   parameter int MAX_BITS = 9,
   parameter int OSR      = 16,
   parameter int LEN_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic [LEN_W-1:0]    len_code,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                two_stop,
   output logic                done,
   output logic [MAX_BITS-1:0] word,
   output logic                done_perr,
   output logic                done_ferr
);

   localparam int CNT_W  = $clog2(OSR);
   localparam int IDX_W  = $clog2(MAX_BITS + 1);
   localparam int SPAN   = MAX_BITS - MIN_BITS;

   rx_state_e          state;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   idx;
   logic [IDX_W-1:0]   len_sel;
   logic [IDX_W-1:0]   lat_len;
   logic               lat_par_en;
   logic               lat_two;
   logic               par_acc;
   logic               perr_r;
   logic               ferr_r;
   logic               stop_more;
   logic               armed;
   logic               mid_pt;
   logic               end_pt;

   always_comb begin
      if (int'(len_code) > SPAN) len_sel = IDX_W'(MAX_BITS);
      else                       len_sel = IDX_W'(MIN_BITS) + IDX_W'(len_code);
   end

   assign mid_pt = (cnt == CNT_W'(OSR/2 - 1));
   assign end_pt = (cnt == CNT_W'(OSR - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         cnt        <= '0;
         idx        <= '0;
         word       <= '0;
         lat_len    <= '0;
         lat_par_en <= 1'b0;
         lat_two    <= 1'b0;
         par_acc    <= 1'b0;
         perr_r     <= 1'b0;
         ferr_r     <= 1'b0;
         stop_more  <= 1'b0;
         armed      <= 1'b0;
         done       <= 1'b0;
         done_perr  <= 1'b0;
         done_ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (line) begin
                     armed <= 1'b1;
                  end else if (armed) begin
                     armed      <= 1'b0;
                     state      <= RX_START;
                     cnt        <= '0;
                     lat_len    <= len_sel;
                     lat_par_en <= par_en;
                     lat_two    <= two_stop;
                     par_acc    <= par_odd;
                  end
               end
               RX_START: begin
                  if (mid_pt) begin
                     cnt <= '0;
                     if (line) begin
                        state <= RX_IDLE;
                     end else begin
                        state  <= RX_DATA;
                        idx    <= '0;
                        word   <= '0;
                        perr_r <= 1'b0;
                        ferr_r <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (end_pt) begin
                     cnt       <= '0;
                     word[idx] <= line;
                     par_acc   <= par_acc ^ line;
                     idx       <= idx + 1'b1;
                     if (idx == lat_len - 1'b1) begin
                        state     <= lat_par_en ? RX_PAR : RX_STOP;
                        stop_more <= lat_two;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (end_pt) begin
                     cnt    <= '0;
                     perr_r <= par_acc ^ line;
                     state  <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (end_pt) begin
                     cnt <= '0;
                     if (stop_more) begin
                        stop_more <= 1'b0;
                        ferr_r    <= ferr_r | ~line;
                     end else begin
                        done      <= 1'b1;
                        done_perr <= perr_r;
                        done_ferr <= ferr_r | ~line;
                        state     <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int WORD_W      = 9,
   parameter bit KEEP_NEWEST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [WORD_W-1:0] word_in,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              rd_ack,
   output logic [WORD_W-1:0] word_out,
   output logic              valid,
   output logic              perr_p,
   output logic              ferr_p,
   output logic              ovr_p
);

   logic good;
   logic load;

   assign good = done & ~perr_in & ~ferr_in;

   generate
      if (KEEP_NEWEST) begin : g_newest
         assign load = good;
      end else begin : g_oldest
         assign load = good & (~valid | rd_ack);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out <= '0;
         valid    <= 1'b0;
         perr_p   <= 1'b0;
         ferr_p   <= 1'b0;
         ovr_p    <= 1'b0;
      end else begin
         perr_p <= done & perr_in;
         ferr_p <= done & ferr_in;
         ovr_p  <= good & valid & ~rd_ack;
         if (load) word_out <= word_in;
         if (good)        valid <= 1'b1;
         else if (rd_ack) valid <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
   import uart_rx_pkg::*;
#(
   parameter int  MIN_BITS    = 5,
   parameter int  MAX_BITS    = 9,
   parameter int  OSR         = 16,
   parameter int  SYNC_STAGES = 2,
   parameter bit  KEEP_NEWEST = 1'b1,
   localparam int LEN_W       = (MAX_BITS > MIN_BITS) ? $clog2(MAX_BITS - MIN_BITS + 1) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                os_tick,
   input  logic                rxd,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic                cfg_par_en,
   input  logic                cfg_par_odd,
   input  logic                cfg_two_stop,
   input  logic                rd_ack,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                rx_valid,
   output logic                par_err,
   output logic                frame_err,
   output logic                overrun
);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart_os_rx: OSR must be even and at least 4");
      end
      if (MIN_BITS < 1 || MAX_BITS < MIN_BITS) begin : g_bad_len
         $error("uart_os_rx: word length range is invalid");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_os_rx: synchronizer needs two or more stages");
      end
   endgenerate

   logic                line_s;
   logic                frame_done;
   logic [MAX_BITS-1:0] frame_word;
   logic                frame_perr;
   logic                frame_ferr;

   uart_rx_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rxd),
      .q_sync  (line_s)
   );

   uart_rx_frame #(
      .MIN_BITS (MIN_BITS),
      .MAX_BITS (MAX_BITS),
      .OSR      (OSR),
      .LEN_W    (LEN_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .line      (line_s),
      .len_code  (cfg_len),
      .par_en    (cfg_par_en),
      .par_odd   (cfg_par_odd),
      .two_stop  (cfg_two_stop),
      .done      (frame_done),
      .word      (frame_word),
      .done_perr (frame_perr),
      .done_ferr (frame_ferr)
   );

   uart_rx_hold #(
      .WORD_W      (MAX_BITS),
      .KEEP_NEWEST (KEEP_NEWEST)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (frame_done),
      .word_in  (frame_word),
      .perr_in  (frame_perr),
      .ferr_in  (frame_ferr),
      .rd_ack   (rd_ack),
      .word_out (rx_word),
      .valid    (rx_valid),
      .perr_p   (par_err),
      .ferr_p   (frame_err),
      .ovr_p    (overrun)
   );

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
   parameter int WORD_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_ack,
   input logic              frame_done,
   input logic              frame_perr,
   input logic              frame_ferr,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid,
   input logic              par_err,
   input logic              frame_err,
   input logic              overrun
);

   // R4 R6
   drop_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && (frame_perr || frame_ferr) && !rd_ack) |=> ($stable(rx_valid) && $stable(rx_word)));

   // R2
   load_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_perr && !frame_ferr) |=> rx_valid);

   // R9
   ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> (rx_valid && !par_err && !frame_err));

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !frame_done) |=> !rx_valid);

   // R4 R6
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err || frame_err) |-> $past(frame_done));

endmodule

bind uart_os_rx uart_os_rx_chk #(.WORD_W(MAX_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_ack     (rd_ack),
   .frame_done (frame_done),
   .frame_perr (frame_perr),
   .frame_ferr (frame_ferr),
   .rx_word    (rx_word),
   .rx_valid   (rx_valid),
   .par_err    (par_err),
   .frame_err  (frame_err),
   .overrun    (overrun)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TICKS_BIT  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic [2:0] cfg_len = 3'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       rd_ack = 1'b0;
   logic [8:0] rx_word;
   logic       rx_valid;
   logic       par_err;
   logic       frame_err;
   logic       overrun;

   int n_run = 0;
   int n_fail = 0;
   int n_perr = 0;
   int n_ferr = 0;
   int n_ovr = 0;
   int tdiv = 1;
   int tcnt = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_os_rx dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .os_tick      (os_tick),
      .rxd          (rxd),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_odd  (cfg_par_odd),
      .cfg_two_stop (cfg_two_stop),
      .rd_ack       (rd_ack),
      .rx_word      (rx_word),
      .rx_valid     (rx_valid),
      .par_err      (par_err),
      .frame_err    (frame_err),
      .overrun      (overrun)
   );

   // tick generator and pulse counters, away from the active edge
   always @(negedge clk) begin
      os_tick <= (tcnt == 0);
      tcnt    <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
      if (rst_n) begin
         if (par_err)   n_perr++;
         if (frame_err) n_ferr++;
         if (overrun)   n_ovr++;
      end
      cycles++;
      if (cycles > 180000 && !finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected<=180000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b);
      rxd = b;
      repeat (TICKS_BIT * tdiv) @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      for (int i = 0; i < n; i++) drive_bit(1'b1);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      @(negedge clk);
   endtask

   function automatic int len_of(input int code);
      return (code > 4) ? 9 : code + 5;
   endfunction

   // pm: 0 none, 1 even, 2 odd
   task automatic send_frame(input int data, input int len, input int pm, input bit two,
                             input bit flip_p, input bit bad1, input bit bad2);
      int p;
      cfg_par_en   = (pm != 0);
      cfg_par_odd  = (pm == 2);
      cfg_two_stop = two;
      drive_bit(1'b0);
      p = (pm == 2) ? 1 : 0;
      for (int i = 0; i < len; i++) begin
         drive_bit(data[i]);
         p ^= data[i];
      end
      if (pm != 0) drive_bit(logic'(p[0] ^ flip_p));
      drive_bit(~bad1);
      if (two) drive_bit(~bad2);
   endtask

   function automatic int pat(input int k, input int len, input int salt);
      int mask = (1 << len) - 1;
      case (k)
         0: return mask;
         1: return 0;
         2: return 32'h155 & mask;
         default: return (salt * 37 + 91) & mask;
      endcase
   endfunction

   initial begin
      int pe0, fe0, ov0, w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 valid", rx_valid, 0);
      chk("R1 word", rx_word, 0);
      chk("R1 flags", {par_err, frame_err, overrun}, 0);
      idle_bits(1);

      // R2 R3 R5 R7 sweep over length, parity and stop settings
      for (int code = 0; code < 5; code++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int two = 0; two < 2; two++) begin
               cfg_len = 3'(code);
               for (int k = 0; k < 4; k++) begin
                  w = pat(k, len_of(code), code * 6 + pm * 2 + two);
                  ack();
                  pe0 = n_perr; fe0 = n_ferr;
                  send_frame(w, len_of(code), pm, bit'(two), 1'b0, 1'b0, 1'b0);
                  idle_bits(1);
                  chk(pm == 0 ? "R2 R3 R5 word" : (two != 0 ? "R2 R3 R7 word" : "R2 R3 word"),
                      rx_word, w);
                  chk("R2 valid", rx_valid, 1);
                  chk("R2 no errors", (n_perr - pe0) + (n_ferr - fe0), 0);
               end
               if (pm != 0) begin
                  // R4 wrong parity bit is flagged and dropped
                  ack();
                  pe0 = n_perr; fe0 = n_ferr;
                  w = pat(3, len_of(code), code + pm);
                  send_frame(w, len_of(code), pm, bit'(two), 1'b1, 1'b0, 1'b0);
                  idle_bits(1);
                  chk("R4 parity error pulse", n_perr - pe0, 1);
                  chk("R4 dropped word keeps valid low", rx_valid, 0);
                  chk("R4 no framing error", n_ferr - fe0, 0);
               end
            end
         end
      end

      // R3 codes above the range select nine bits
      for (int code = 5; code < 8; code++) begin
         cfg_len = 3'(code);
         ack();
         w = 9'h1A5 ^ (code << 6);
         send_frame(w, 9, 0, 1'b0, 1'b0, 1'b0, 1'b0);
         idle_bits(1);
         chk("R3 capped length", rx_word, w & 9'h1FF);
      end

      // R2 R4 exhaustive five-bit words with even parity
      cfg_len = 3'd0;
      for (int v = 0; v < 32; v++) begin
         ack();
         pe0 = n_perr;
         send_frame(v, 5, 1, 1'b0, 1'b0, 1'b0, 1'b0);
         idle_bits(1);
         chk("R2 R4 five-bit word", rx_word, v);
         chk("R4 even parity accepted", n_perr - pe0, 0);
      end

      // R6 low first stop bit
      cfg_len = 3'd3;
      ack();
      fe0 = n_ferr;
      send_frame(8'h3C, 8, 0, 1'b0, 1'b0, 1'b1, 1'b0);
      idle_bits(2);
      chk("R6 framing error pulse", n_ferr - fe0, 1);
      chk("R6 word dropped", rx_valid, 0);

      // R7 low second stop bit
      fe0 = n_ferr;
      send_frame(8'hC3, 8, 2, 1'b1, 1'b0, 1'b0, 1'b1);
      idle_bits(2);
      chk("R7 second stop checked", n_ferr - fe0, 1);
      chk("R7 word dropped", rx_valid, 0);

      // R11 line stuck low after a bad frame must not start a frame
      fe0 = n_ferr; pe0 = n_perr;
      send_frame(8'h81, 8, 0, 1'b0, 1'b0, 1'b1, 1'b0);
      drive_bit(1'b0); drive_bit(1'b0); drive_bit(1'b0);
      idle_bits(2);
      chk("R11 only one framing error", n_ferr - fe0, 1);
      chk("R11 no word from stuck line", rx_valid, 0);
      send_frame(8'h5E, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_bits(1);
      chk("R11 resync word", rx_word, 8'h5E);
      chk("R11 no parity error", n_perr - pe0, 0);

      // R8 short low glitch
      ack();
      fe0 = n_ferr; pe0 = n_perr;
      rxd = 1'b0;
      repeat (5) @(negedge clk);
      idle_bits(3);
      chk("R8 glitch gives no word", rx_valid, 0);
      chk("R8 glitch gives no flag", (n_ferr - fe0) + (n_perr - pe0), 0);
      send_frame(8'hA7, 8, 1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_bits(1);
      chk("R8 frame after glitch", rx_word, 8'hA7);

      // R9 overrun replaces the held word; R10 read clears valid
      ack();
      ov0 = n_ovr;
      send_frame(8'h11, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_bits(1);
      chk("R9 no overrun on first word", n_ovr - ov0, 0);
      send_frame(8'hEE, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      idle_bits(1);
      chk("R9 overrun pulse", n_ovr - ov0, 1);
      chk("R9 newest word held", rx_word, 8'hEE);
      chk("R9 valid stays set", rx_valid, 1);
      ack();
      chk("R10 read clears valid", rx_valid, 0);
      chk("R10 word kept after read", rx_word, 8'hEE);

      // R12 slower tick spacing, 32 clocks per bit
      tdiv = 2;
      idle_bits(1);
      send_frame(8'h6B, 8, 2, 1'b1, 1'b0, 1'b0, 1'b0);
      idle_bits(1);
      chk("R12 word at half tick rate", rx_word, 8'h6B);
      chk("R12 valid at half tick rate", rx_valid, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule